// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is one bank of general-purpose pins behind a small register bus. Software sets the value that each pin drives and whether it drives at all. It reads back the state the pins actually carry. Each pin can also be set up as an interrupt source. The source can be either level-sensitive or edge-sensitive, and its polarity is selectable. A detected event sets a sticky status bit. The status bits that are enabled are ORed onto one interrupt line for the whole bank.

Each register can be reached at three addresses: plain write, bit-set and bit-clear. With the set and clear addresses, software can change single bits without a read-modify-write. A pin is gated twice. The arm register decides whether the pin records events at all. The enable register decides whether a recorded event reaches the interrupt line.

The bus is a plain strobe interface with no back-pressure. A write takes effect at the clock edge where `wr_en` is high. A read strobe returns data on `rdata` after that edge, and `rdata` then holds the value until the next read.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads 0, `pin_out` and `pin_oe` are 0, and `irq` is 0.
- R2: The register index is `addr[7:4]`: 0 drive value, 1 pin state, 2 drive enable, 3 arm, 4 interrupt enable, 5 mode (1 = level, 0 = edge), 6 polarity (1 = high/rising, 0 = low/falling), 7 status. With `addr[3:2]`=0, a write replaces the register. A read returns the register on the cycle after the strobe. `pin_out` mirrors register 0 and `pin_oe` mirrors register 2.
- R3: With `addr[3:2]`=1 (offset +0x4), a write ORs `wdata` into the register. With `addr[3:2]`=2 (offset +0x8), a write clears the bits that are 1 in `wdata`. Other bits keep their value.
- R4: Register 1 shows `pin_in` through a two-flop synchronizer, whatever the drive enable holds. Writes to register 1 have no effect.
- R5: In edge mode, an armed pin sets its status bit on a rising edge when its polarity bit is 1, and on a falling edge when it is 0. The opposite edge and a steady pin set nothing. Status bits are sticky.
- R6: In level mode, an armed pin sets its status bit on every cycle its active level is present. After the level goes away, a clear leaves the bit at 0.
- R7: A pin whose arm bit is 0 never sets its status bit.
- R8: `irq` is 1 exactly when some bit is set in both status and interrupt enable.
- R9: If a pin event and a software clear hit the same status bit in one cycle, the bit stays set.
- R10: Addresses with `addr[3:2]`=3 or an index of 8 or more read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address: index in [7:4], access kind in [3:2] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| pin_in | input | 32 | Pin levels, asynchronous |
| pin_out | output | 32 | Value to drive on each pin |
| pin_oe | output | 32 | 1 where the pin drives |
| irq | output | 1 | Bank interrupt line |

## Verification
Each result has its own due time. A write changes the register, `pin_out`, `pin_oe` and `irq` at the same edge. Read data appears one edge after the strobe. The pin-state register follows a pin change two edges later. A status bit, and with it `irq`, follows three edges after a pin change. The bench drives at falling edges and waits four rising edges after each pin change. It samples every output at a falling edge, after the edge where the result is due.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    ACC_WRITE = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLEAR = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    RG_DRIVE  = 3'd0,
    RG_STATE  = 3'd1,
    RG_DRV_EN = 3'd2,
    RG_ARM    = 3'd3,
    RG_IEN    = 3'd4,
    RG_MODE   = 3'd5,
    RG_POL    = 3'd6,
    RG_STAT   = 3'd7
  } reg_e;

  localparam int NUM_REGS = 8;
  localparam int SYNC_DEPTH = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] arm,
  input  logic [WIDTH-1:0] mode_level,
  input  logic [WIDTH-1:0] pol_high,
  output logic [WIDTH-1:0] event_o
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= level;
  end

  // active means the pin sits at its selected level; for edges the
  // pin must also have just moved there
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic active, moved;
    assign active = (level[p] == pol_high[p]);
    assign moved  = (level[p] != prev[p]);
    assign event_o[p] = arm[p] & active & (mode_level[p] | moved);
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_PINS-1:0] wdata,
  output logic [N_PINS-1:0] rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 4;

  logic [IDX_W-1:0]  idx;
  acc_e              acc;
  logic              mapped;
  logic [N_PINS-1:0] rf [NUM_REGS];
  logic [N_PINS-1:0] state_s;
  logic [N_PINS-1:0] pin_event;
  logic [N_PINS-1:0] arm_v, ien_v, mode_v, pol_v, stat_v;

  assign idx    = addr[ADDR_W-1:4];
  assign acc    = acc_e'(addr[3:2]);
  assign mapped = (idx < IDX_W'(NUM_REGS)) && (acc != ACC_NONE);

  function automatic logic [N_PINS-1:0] merge(
    input logic [N_PINS-1:0] cur,
    input logic [N_PINS-1:0] wd,
    input acc_e              a
  );
    case (a)
      ACC_SET:   return cur | wd;
      ACC_CLEAR: return cur & ~wd;
      ACC_WRITE: return wd;
      default:   return cur;
    endcase
  endfunction

  gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (state_s)
  );

  gpio_detect #(.WIDTH(N_PINS)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (state_s),
    .arm        (arm_v),
    .mode_level (mode_v),
    .pol_high   (pol_v),
    .event_o    (pin_event)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && mapped && (idx == IDX_W'(g));
    if (g == int'(RG_STATE)) begin : g_ro
      assign rf[g] = state_s;
    end else if (g == int'(RG_STAT)) begin : g_sticky
      logic [N_PINS-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= (hit ? merge(q, wdata, acc) : q) | pin_event;
      end
      assign rf[g] = q;
    end else begin : g_rw
      logic [N_PINS-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= merge(q, wdata, acc);
      end
      assign rf[g] = q;
    end
  end

  assign arm_v  = rf[RG_ARM];
  assign ien_v  = rf[RG_IEN];
  assign mode_v = rf[RG_MODE];
  assign pol_v  = rf[RG_POL];
  assign stat_v = rf[RG_STAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_en)  rdata <= mapped ? rf[idx[2:0]] : '0;
  end

  assign pin_out = rf[RG_DRIVE];
  assign pin_oe  = rf[RG_DRV_EN];
  assign irq     = |(stat_v & ien_v);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int N_PINS = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_PINS-1:0] rdata,
  input logic [N_PINS-1:0] pin_in,
  input logic [N_PINS-1:0] din,
  input logic [N_PINS-1:0] arm,
  input logic [N_PINS-1:0] ien,
  input logic [N_PINS-1:0] stat,
  input logic              irq
);
  logic [1:0] age;
  logic       stat_wr, unmapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign stat_wr  = wr_en && (addr[ADDR_W-1:4] == (ADDR_W-4)'(7)) && (addr[3:2] != 2'd3);
  assign unmapped = (addr[3:2] == 2'd3) || (addr[ADDR_W-1:4] > (ADDR_W-4)'(7));

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (!irq && stat == '0)); // R1

  AST_STATE_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (din == $past(pin_in, 2))); // R4

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> (($past(stat) & ~stat) == '0)); // R5

  AST_UNARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat & ~$past(stat) & ~$past(arm)) == '0)); // R7

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && unmapped) |=> (rdata == '0)); // R10
endmodule

bind gpio_bank gpio_bank_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .addr   (addr),
  .rdata  (rdata),
  .pin_in (pin_in),
  .din    (state_s),
  .arm    (arm_v),
  .ien    (ien_v),
  .stat   (stat_v),
  .irq    (irq)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 54;
  // row: op[45:44] (0 write, 1 read+compare, 2 set pins and wait,
  // 3 compare output sel by addr: 0 irq, 1 pin_out, 2 pin_oe),
  // req[43:40], addr[39:32], data/expected[31:0]
  localparam logic [45:0] VEC [NV] = '{
    {2'd0, 4'd2,  8'h00, 32'hA5A5_0000},  // R2
    {2'd1, 4'd2,  8'h00, 32'hA5A5_0000},
    {2'd3, 4'd2,  8'h01, 32'hA5A5_0000},
    {2'd0, 4'd3,  8'h04, 32'h0000_00FF},  // R3 set
    {2'd1, 4'd3,  8'h00, 32'hA5A5_00FF},
    {2'd0, 4'd3,  8'h08, 32'hA500_000F},  // R3 clear
    {2'd1, 4'd3,  8'h00, 32'h00A5_00F0},
    {2'd0, 4'd2,  8'h20, 32'hFFFF_0000},
    {2'd1, 4'd2,  8'h20, 32'hFFFF_0000},
    {2'd3, 4'd2,  8'h02, 32'hFFFF_0000},
    {2'd0, 4'd10, 8'h0C, 32'h1234_5678},  // R10
    {2'd1, 4'd10, 8'h00, 32'h00A5_00F0},
    {2'd1, 4'd10, 8'h0C, 32'h0000_0000},
    {2'd1, 4'd10, 8'h80, 32'h0000_0000},
    {2'd0, 4'd10, 8'h84, 32'hFFFF_FFFF},
    {2'd1, 4'd10, 8'h20, 32'hFFFF_0000},
    {2'd2, 4'd4,  8'h00, 32'h0010_0F00},  // R4
    {2'd1, 4'd4,  8'h10, 32'h0010_0F00},
    {2'd0, 4'd4,  8'h10, 32'hFFFF_FFFF},
    {2'd1, 4'd4,  8'h10, 32'h0010_0F00},
    {2'd0, 4'd5,  8'h34, 32'h0000_0003},  // R5 arm pins 0,1
    {2'd0, 4'd5,  8'h64, 32'h0000_0001},
    {2'd1, 4'd5,  8'h70, 32'h0000_0000},
    {2'd2, 4'd5,  8'h00, 32'h0010_0F01},
    {2'd1, 4'd5,  8'h70, 32'h0000_0001},
    {2'd3, 4'd8,  8'h00, 32'h0000_0000},  // R8
    {2'd0, 4'd8,  8'h44, 32'h0000_0001},
    {2'd3, 4'd8,  8'h00, 32'h0000_0001},
    {2'd0, 4'd8,  8'h78, 32'hFFFF_FFFF},
    {2'd1, 4'd8,  8'h70, 32'h0000_0000},
    {2'd3, 4'd8,  8'h00, 32'h0000_0000},
    {2'd2, 4'd5,  8'h00, 32'h0010_0F03},
    {2'd1, 4'd5,  8'h70, 32'h0000_0000},
    {2'd2, 4'd5,  8'h00, 32'h0010_0F01},
    {2'd1, 4'd5,  8'h70, 32'h0000_0002},
    {2'd3, 4'd8,  8'h00, 32'h0000_0000},
    {2'd0, 4'd7,  8'h78, 32'hFFFF_FFFF},  // R7
    {2'd2, 4'd7,  8'h00, 32'h0010_0F05},
    {2'd2, 4'd7,  8'h00, 32'h0010_0F01},
    {2'd1, 4'd7,  8'h70, 32'h0000_0000},
    {2'd0, 4'd6,  8'h54, 32'h0000_0008},  // R6
    {2'd0, 4'd6,  8'h64, 32'h0000_0008},
    {2'd0, 4'd6,  8'h34, 32'h0000_0008},
    {2'd1, 4'd6,  8'h70, 32'h0000_0000},
    {2'd2, 4'd6,  8'h00, 32'h0010_0F09},
    {2'd1, 4'd6,  8'h70, 32'h0000_0008},
    {2'd0, 4'd9,  8'h78, 32'h0000_0008},  // R9
    {2'd1, 4'd9,  8'h70, 32'h0000_0008},
    {2'd2, 4'd6,  8'h00, 32'h0010_0F01},
    {2'd0, 4'd6,  8'h78, 32'h0000_0008},
    {2'd1, 4'd6,  8'h70, 32'h0000_0000},
    {2'd2, 4'd6,  8'h00, 32'h0010_0F09},
    {2'd0, 4'd8,  8'h44, 32'h0000_0008},
    {2'd3, 4'd8,  8'h00, 32'h0000_0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int          n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk); pin_in = v;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(1, pin_out, 32'h0);
    check(1, pin_oe, 32'h0);
    check(1, {31'h0, irq}, 32'h0);
    for (int r = 0; r < 8; r++) begin
      do_read(8'(r << 4), d);
      check(1, d, 32'h0);
    end

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      int          req;
      logic [7:0]  a;
      logic [31:0] v;
      op = VEC[i][45:44]; req = int'(VEC[i][43:40]); a = VEC[i][39:32]; v = VEC[i][31:0];
      case (op)
        2'd0: do_write(a, v);
        2'd1: begin do_read(a, d); check(req, d, v); end
        2'd2: set_pins(v);
        default: begin
          @(negedge clk);
          case (a)
            8'h00:   check(req, {31'h0, irq}, v);
            8'h01:   check(req, pin_out, v);
            default: check(req, pin_oe, v);
          endcase
        end
      endcase
    end

    // R1: reset mid-run clears outputs while irq is high
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(1, {31'h0, irq}, 32'h0);
    check(1, pin_out, 32'h0);
    check(1, pin_oe, 32'h0);
    do_read(8'h70, d);
    check(1, d, 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule